// File: doc/BRIEF.md
# Power-fail chip-enable gate

This block sits between a processor's memory chip-enable and up to four banks of low-power static RAM. It write-protects those banks while the supply is failing or coming back. An external comparator reports power failure as a digital, asynchronous level. A threshold-select level is registered and handed on to that comparator. A two-bit bank select chooses which of the four active-low bank enables carries the request.

In normal running, the selected enable follows the request directly. When a failure is flagged and no access is in progress, every enable goes high at once. An access that is already in progress may run on until the request rises, but only for a bounded number of cycles. After that the banks are cut off regardless of the request. When the failure clears, all enables stay high for a settle delay. The same settle phase follows reset, so the banks are closed from power-up until the first delay has elapsed.

Top module: `pfail_ce_gate`

## Requirements
- R1: From reset release, all bank enables stay high for at least RECOVER_CYC clock cycles, whatever the request does.
- R2: In normal running, with bank_sel = k, bank_en_n[k] equals req_n in the same cycle and every other enable is high.
- R3: The power-fail input is taken through a two-flop synchroniser, so the gate reacts to it from the third rising edge after it changes.
- R4: When the synchronised failure is seen while req_n is high, all enables are high from the next cycle and remain high while the failure lasts.
- R5: When the synchronised failure is seen while req_n is low, the selected enable keeps following the request until req_n rises; from then on all enables are high.
- R6: An access held past failure is cut off after WP_TIMEOUT_CYC cycles of overrun, so the enables go high even though req_n stays low.
- R7: After the synchronised failure clears, all enables stay high for at least RECOVER_CYC cycles, and normal running resumes only in a cycle in which req_n is high.
- R8: A request that begins during overrun, protection or settle never drives any enable low.
- R9: thr_sel_out equals the thr_sel_in value sampled at the previous rising edge (reset value 0).
- R10: At most one bank enable is low in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | 1 | Active-low chip-enable request from the processor |
| bank_sel | input | 2 | Bank index whose enable carries the request |
| pfail_async | input | 1 | Power-fail level from the external comparator, 1 = failing, asynchronous |
| thr_sel_in | input | 1 | Threshold choice for the comparator |
| thr_sel_out | output | 1 | Registered threshold choice driven to the comparator |
| bank_en_n | output | 4 | Active-low conditioned bank enables |

## Verification
Several properties are checked on every cycle: there is never more than one low enable, and any low enable matches the selected bank. The enables are forced high when the request is idle, after boot, in the protect and settle states, and after an idle-time failure. The overrun window is bounded by a cycle counter, and the threshold follows its input with one cycle of delay. Some behaviour can only be shown by the bench's scenarios against its reference model. This covers the exact cycle in which an access is cut off by the timeout, the length of the settle phase, its extension while a request is held, and the rejection of requests raised in each protected phase.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
    typedef enum logic [1:0] {
        ST_NORMAL  = 2'd0,
        ST_FINISH  = 2'd1,
        ST_PROTECT = 2'd2,
        ST_RECOVER = 2'd3
    } gate_state_e;
endpackage

// File: rtl/pfg_sync.sv
module pfg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pfg_timer.sv
module pfg_timer #(
    parameter int MAX_COUNT = 255,
    localparam int W = $clog2(MAX_COUNT + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    output logic [W-1:0] count
);
    logic [W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (clear)                         count_d = '0;
        else if (count_q != W'(MAX_COUNT)) count_d = count_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count = count_q;
endmodule

// File: rtl/pfg_bank_decode.sv
module pfg_bank_decode #(
    parameter int NUM_BANKS = 4,
    localparam int SEL_W = $clog2(NUM_BANKS)
) (
    input  logic                 enable,
    input  logic [SEL_W-1:0]     sel,
    output logic [NUM_BANKS-1:0] en_n
);
    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        assign en_n[i] = !(enable && (sel == SEL_W'(i)));
    end
endmodule

// File: rtl/pfail_ce_gate.sv
module pfail_ce_gate
    import pfg_pkg::*;
#(
    parameter int NUM_BANKS      = 4,
    parameter int WP_TIMEOUT_CYC = 256,
    parameter int RECOVER_CYC    = 1000000,
    parameter int SYNC_STAGES    = 2,
    localparam int SEL_W = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_n,
    input  logic [SEL_W-1:0]     bank_sel,
    input  logic                 pfail_async,
    input  logic                 thr_sel_in,
    output logic                 thr_sel_out,
    output logic [NUM_BANKS-1:0] bank_en_n
);
    localparam int CNT_MAX = (WP_TIMEOUT_CYC > RECOVER_CYC) ? WP_TIMEOUT_CYC : RECOVER_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        gate_state_e st;
        logic        thr;
    } gate_regs_t;

    gate_regs_t  r_d, r_q;
    gate_state_e st_q;
    logic        pf_sync;
    logic        tmr_clear;
    logic [CNT_W-1:0] tmr_count;
    logic        wp_expired, settle_done, pass_req;

    pfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pfail_async),
        .q     (pf_sync)
    );

    pfg_timer #(.MAX_COUNT(CNT_MAX)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (tmr_clear),
        .count (tmr_count)
    );

    assign wp_expired  = (tmr_count >= CNT_W'(WP_TIMEOUT_CYC - 1));
    assign settle_done = (tmr_count >= CNT_W'(RECOVER_CYC - 1));
    assign st_q        = r_q.st;

    always_comb begin
        r_d     = r_q;
        r_d.thr = thr_sel_in;
        case (r_q.st)
            ST_NORMAL: begin
                if (pf_sync) r_d.st = req_n ? ST_PROTECT : ST_FINISH;
            end
            ST_FINISH: begin
                if (req_n || wp_expired) r_d.st = ST_PROTECT;
            end
            ST_PROTECT: begin
                if (!pf_sync) r_d.st = ST_RECOVER;
            end
            ST_RECOVER: begin
                if (pf_sync)                     r_d.st = ST_PROTECT;
                else if (settle_done && req_n)   r_d.st = ST_NORMAL;
            end
            default: r_d.st = ST_PROTECT;
        endcase
        tmr_clear = (r_d.st != r_q.st);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_RECOVER, thr: 1'b0};
        else        r_q <= r_d;
    end

    assign pass_req    = ((r_q.st == ST_NORMAL) || (r_q.st == ST_FINISH)) && !req_n;
    assign thr_sel_out = r_q.thr;

    pfg_bank_decode #(.NUM_BANKS(NUM_BANKS)) u_decode (
        .enable (pass_req),
        .sel    (bank_sel),
        .en_n   (bank_en_n)
    );
endmodule

// File: rtl/pfg_checker.sv
module pfg_checker
    import pfg_pkg::*;
#(
    parameter int NUM_BANKS      = 4,
    parameter int WP_TIMEOUT_CYC = 256,
    parameter int RECOVER_CYC    = 1000000,
    localparam int SEL_W = $clog2(NUM_BANKS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_n,
    input logic [SEL_W-1:0]     bank_sel,
    input logic                 thr_sel_in,
    input logic                 thr_sel_out,
    input logic [NUM_BANKS-1:0] bank_en_n,
    input logic                 pf_sync,
    input gate_state_e          st_q
);
    int unsigned since_q, run_q;
    logic any_low;

    assign any_low = !(&bank_en_n);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= 0;
            run_q   <= 0;
        end else begin
            if (since_q < RECOVER_CYC + 1) since_q <= since_q + 1;
            run_q <= (pf_sync && any_low) ? run_q + 1 : 0;
        end
    end

    a_r1_boot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q < RECOVER_CYC) |-> !any_low);

    a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        req_n |-> !any_low);

    a_r2_selected_bank: assert property (@(posedge clk) disable iff (!rst_n)
        any_low |-> !bank_en_n[bank_sel]);

    a_r4_fail_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pf_sync) && $past(req_n)) |-> !any_low);

    a_r6_bounded_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_sync && any_low) |-> (run_q <= WP_TIMEOUT_CYC));

    a_r8_locked_states: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_PROTECT) || (st_q == ST_RECOVER)) |-> !any_low);

    a_r9_thr_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q != 0) |-> (thr_sel_out == $past(thr_sel_in)));

    a_r10_single_low: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~bank_en_n));
endmodule

bind pfail_ce_gate pfg_checker #(
    .NUM_BANKS      (NUM_BANKS),
    .WP_TIMEOUT_CYC (WP_TIMEOUT_CYC),
    .RECOVER_CYC    (RECOVER_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_n       (req_n),
    .bank_sel    (bank_sel),
    .thr_sel_in  (thr_sel_in),
    .thr_sel_out (thr_sel_out),
    .bank_en_n   (bank_en_n),
    .pf_sync     (pf_sync),
    .st_q        (st_q)
);

// File: tb/tb_pfail_ce_gate.sv
`timescale 1ns/1ps
module tb_pfail_ce_gate;
    localparam int WP  = 8;
    localparam int REC = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_n = 1'b1;
    logic [1:0] bank_sel = 2'd0;
    logic       pfail_async = 1'b0;
    logic       thr_sel_in = 1'b0;
    logic       thr_sel_out;
    logic [3:0] bank_en_n;

    int total = 0, failed = 0, cycles = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pfail_ce_gate #(.NUM_BANKS(4), .WP_TIMEOUT_CYC(WP), .RECOVER_CYC(REC)) dut (
        .clk(clk), .rst_n(rst_n), .req_n(req_n), .bank_sel(bank_sel),
        .pfail_async(pfail_async), .thr_sel_in(thr_sel_in),
        .thr_sel_out(thr_sel_out), .bank_en_n(bank_en_n)
    );

    // Behavioural reference: 0 normal, 1 overrun, 2 protect, 3 settle
    int  m_mode, m_cnt;
    bit  m_s1, m_s2, m_thr, m_boot, m_timeout;

    always @(posedge clk or negedge rst_n) begin
        int nxt;
        if (!rst_n) begin
            m_mode <= 3; m_cnt <= 0; m_s1 <= 0; m_s2 <= 0;
            m_thr <= 0; m_boot <= 1; m_timeout <= 0;
        end else begin
            nxt = m_mode;
            if (m_mode == 0) begin
                if (m_s2) nxt = req_n ? 2 : 1;
            end else if (m_mode == 1) begin
                if (req_n) nxt = 2;
                else if (m_cnt >= WP - 1) begin nxt = 2; m_timeout <= 1; end
            end else if (m_mode == 2) begin
                if (!m_s2) nxt = 3;
            end else begin
                if (m_s2) nxt = 2;
                else if (m_cnt >= REC - 1 && req_n) nxt = 0;
            end
            if (nxt == 3) m_timeout <= 0;
            if (nxt != 3) m_boot <= 0;
            m_cnt  <= (nxt != m_mode) ? 0 : m_cnt + 1;
            m_mode <= nxt;
            m_s1   <= pfail_async;
            m_s2   <= m_s1;
            m_thr  <= thr_sel_in;
        end
    end

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        logic [3:0] exp;
        string tag;
        if (!done) begin
            if (!rst_n) begin
                check("R1 reset enables", bank_en_n, 4'hF);
                check("R9 reset threshold", {3'b0, thr_sel_out}, 4'h0);
            end else begin
                exp = ((m_mode == 0 || m_mode == 1) && !req_n) ? ~(4'b1 << bank_sel) : 4'hF;
                if (m_boot)                       tag = "R1 boot hold";
                else if (m_mode == 0 && m_s2)     tag = "R3 failure seen";
                else if (m_mode == 0)             tag = "R2 normal follow";
                else if (m_mode == 1)             tag = "R5 overrun follow";
                else if (m_mode == 2 && m_timeout) tag = "R6 timeout cut";
                else if (m_mode == 2 && !req_n)   tag = "R8 request ignored";
                else if (m_mode == 2)             tag = "R4 protected";
                else if (!req_n)                  tag = "R8 request in settle";
                else                              tag = "R7 settle hold";
                check(tag, bank_en_n, exp);
                check("R9 threshold", {3'b0, thr_sel_out}, {3'b0, m_thr});
                check("R10 single low", {3'b0, ($countones(~bank_en_n) > 1)}, 4'h0);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            done = 1;
            total++; failed++;
            $display("FAIL watchdog all-requirements actual=running expected=finished");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        // R1/R8: request held low through the boot settle phase
        req_n = 1'b0; step(REC + 5);
        req_n = 1'b1; step(3);
        // R2: each bank in turn, threshold toggled along the way (R9)
        for (int b = 0; b < 4; b++) begin
            bank_sel = 2'(b); thr_sel_in = ~thr_sel_in;
            req_n = 1'b0; step(3);
            req_n = 1'b1; step(2);
        end
        // R3/R4: failure while idle, then request ignored (R8)
        pfail_async = 1'b1; step(6);
        req_n = 1'b0; step(4);
        req_n = 1'b1; step(3);
        pfail_async = 1'b0; step(5);
        // R7/R8: request raised during settle extends it
        req_n = 1'b0; thr_sel_in = ~thr_sel_in; step(REC + 4);
        req_n = 1'b1; step(4);
        // R5: access ends inside the overrun window
        bank_sel = 2'd1; req_n = 1'b0; step(2);
        pfail_async = 1'b1; step(5);
        req_n = 1'b1; step(4);
        req_n = 1'b0; step(3);
        req_n = 1'b1; pfail_async = 1'b0; step(REC + 5);
        // R6: access held past the timeout
        bank_sel = 2'd2; req_n = 1'b0; step(2);
        pfail_async = 1'b1; step(WP + 10);
        req_n = 1'b1; step(2);
        pfail_async = 1'b0; step(REC + 5);
        // R2: normal running restored
        bank_sel = 2'd3; req_n = 1'b0; step(3);
        req_n = 1'b1; step(3);
        done = 1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule